// File: doc/BRIEF.md
# Match-Compare Timer with Pulse-Width Outputs

This block is a free-running up-counter with a programmable prescaler and four compare channels. The count moves forward only on qualified ticks from an upstream clock-source selector. The prescaler sets how many ticks make up one count step. Each compare channel holds a value. When a count step arrives while the counter equals that value, the channel raises its flag and applies its output action to its output pin. It can also return the counter to zero, halt counting, or both.

In pulse-width mode the first three channels stop driving their latched output level. Each of these pins instead goes high once the count reaches its compare value and stays high until the period restarts. The last channel sets the shared period: whenever pulse-width mode is on for any channel, a match on the last channel returns the count to zero. A new compare value written while the output runs changes the pulse width at once. Software uses a flat write port and a combinational read port.

Top module: `match_pwm_timer`

Register map (word addresses): 0 control {bit1 hold-clear, bit0 run}; 1 prescale limit; 2 count (read only, writes ignored); 3 flags (write 1 to clear, bit i = channel i); 4 interrupt enables (bit i = channel i); 5 pulse-width enables (bits 2:0); 8..11 compare values of channels 0..3; 12..15 channel controls {bit4 initial level, bits3:2 action, bit1 halt, bit0 zero-on-match}.

## Requirements
- R1: After reset the count, flags, run bit, compare outputs and irq all read 0.
- R2: With prescale limit P and run set, the count increments once per P+1 ticks. Ticks while run is 0 leave the count unchanged.
- R3: While control bit1 is set, the count and the prescale counter are forced to 0 at the next clock edge. Writes to the count address have no effect.
- R4: A match happens when a count step arrives while the count equals a channel's compare value. It sets that channel's flag bit.
- R5: A match on a channel whose control bit0 is set makes the next count 0 instead of count+1.
- R6: A match on a channel whose control bit1 is set clears the run bit, and the count holds the matched value.
- R7: The action field (bits 3:2) does the following on a match: 0 keeps the output, 1 drives it 0, 2 drives it 1, 3 toggles it. Writing a channel control loads bit4 as the output level at once.
- R8: Writing 1 to a flag bit clears it, and a match in the same cycle wins over the clear. irq is high when any flag with its enable bit set is high.
- R9: With its pulse-width bit set, channel i (i<3) outputs 1 when count >= its compare value and 0 otherwise, so a value of 0 gives a constant high. Bit 3 of the pulse-width register does not exist and reads 0.
- R10: While any pulse-width bit is set, a match on channel 3 makes the next count 0 even if its zero-on-match bit is clear.
- R11: Matches on several channels in one step set all their flags together. A halt from any one of them stops the counter.
- R12: Writing a new compare value to a running pulse-width channel changes its output from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read data, combinational |
| tick | input | 1 | Count-enable tick from source selector |
| match_out | output | 4 | Compare channel outputs |
| flags | output | 4 | Match flags |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can collide in one cycle: a flag being set by a match and software clearing the same flag. The bench provokes this by issuing a write-1-to-clear in exactly the cycle that carries the matching tick. It then expects the flag to remain set. A second collision comes from three channels programmed with the same compare value, one of them with halt. The bench judges it by all three flags set together, the run bit cleared, and the count frozen at the shared value.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } act_e;

    typedef struct packed {
        logic init;
        act_e act;
        logic stop;
        logic rst;
    } mcfg_t;

    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_PRESC = 1;
    localparam int ADDR_COUNT = 2;
    localparam int ADDR_FLAGS = 3;
    localparam int ADDR_IRQEN = 4;
    localparam int ADDR_PWMEN = 5;
    localparam int MV_BASE    = 8;

endpackage

// File: rtl/mpt_prescale.sv
module mpt_prescale #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         step
);
    logic [W-1:0] pc_d, pc_q;

    always_comb begin
        pc_d = pc_q;
        step = 1'b0;
        if (clr) begin
            pc_d = '0;
        end else if (tick && run) begin
            // >= keeps the divider sane if the limit is lowered mid-count
            if (pc_q >= limit) begin
                pc_d = '0;
                step = 1'b1;
            end else begin
                pc_d = pc_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end
endmodule

// File: rtl/mpt_match_chan.sv
module mpt_match_chan
    import mpt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] count,
    input  logic [W-1:0] value,
    input  act_e         act,
    input  logic         load,
    input  logic         init,
    input  logic         pwm,
    output logic         hit,
    output logic         pin
);
    logic lvl_d, lvl_q;

    always_comb begin
        hit   = step && (count == value);
        lvl_d = lvl_q;
        if (load) begin
            lvl_d = init;
        end else if (hit) begin
            unique case (act)
                ACT_KEEP:   lvl_d = lvl_q;
                ACT_LOW:    lvl_d = 1'b0;
                ACT_HIGH:   lvl_d = 1'b1;
                ACT_TOGGLE: lvl_d = ~lvl_q;
                default:    lvl_d = lvl_q;
            endcase
        end
        pin = pwm ? (count >= value) : lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/match_pwm_timer.sv
module match_pwm_timer
    import mpt_pkg::*;
#(
    parameter int CW = 32,
    parameter int NM = 4,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_data,
    input  logic          tick,
    output logic [NM-1:0] match_out,
    output logic [NM-1:0] flags,
    output logic          irq
);
    localparam int NP      = NM - 1;
    localparam int PER     = NM - 1;
    localparam int MC_BASE = MV_BASE + NM;
    localparam int CFGW    = $bits(mcfg_t);

    typedef struct packed {
        logic                   run;
        logic                   clr;
        logic [CW-1:0]          limit;
        logic [CW-1:0]          count;
        logic [NM-1:0]          flags;
        logic [NM-1:0]          irq_en;
        logic [NP-1:0]          pwm_en;
        logic [NM-1:0][CW-1:0]  mr;
        mcfg_t [NM-1:0]         cfg;
    } state_t;

    state_t s_d, s_q;

    logic          step;
    logic [NM-1:0] hit;
    logic [NM-1:0] cfg_load;
    logic [NM-1:0] rst_mask, stop_mask;
    logic [NM-1:0] pwm_vec;
    logic [NM-1:0] flag_clr;
    logic          rst_any, stop_any;
    logic [CW-1:0] count_q;
    logic          run_q, clr_q;

    mpt_prescale #(.W(CW)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .run   (s_q.run),
        .clr   (s_q.clr),
        .limit (s_q.limit),
        .step  (step)
    );

    for (genvar g = 0; g < NM; g++) begin : g_chan
        if (g < NP) begin : g_pwm
            assign pwm_vec[g] = s_q.pwm_en[g];
        end else begin : g_per
            assign pwm_vec[g] = 1'b0;
        end
        assign rst_mask[g]  = s_q.cfg[g].rst;
        assign stop_mask[g] = s_q.cfg[g].stop;

        mpt_match_chan #(.W(CW)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (step),
            .count (s_q.count),
            .value (s_q.mr[g]),
            .act   (s_q.cfg[g].act),
            .load  (cfg_load[g]),
            .init  (wr_data[CFGW-1]),
            .pwm   (pwm_vec[g]),
            .hit   (hit[g]),
            .pin   (match_out[g])
        );
    end

    always_comb begin
        s_d      = s_q;
        cfg_load = '0;
        flag_clr = '0;

        if (wr_en) begin
            if (wr_addr == AW'(ADDR_CTRL)) begin
                s_d.run = wr_data[0];
                s_d.clr = wr_data[1];
            end
            if (wr_addr == AW'(ADDR_PRESC)) s_d.limit  = wr_data;
            if (wr_addr == AW'(ADDR_FLAGS)) flag_clr   = wr_data[NM-1:0];
            if (wr_addr == AW'(ADDR_IRQEN)) s_d.irq_en = wr_data[NM-1:0];
            if (wr_addr == AW'(ADDR_PWMEN)) s_d.pwm_en = wr_data[NP-1:0];
            for (int i = 0; i < NM; i++) begin
                if (wr_addr == AW'(MV_BASE + i)) s_d.mr[i] = wr_data;
                if (wr_addr == AW'(MC_BASE + i)) begin
                    s_d.cfg[i]  = mcfg_t'(wr_data[CFGW-1:0]);
                    cfg_load[i] = 1'b1;
                end
            end
        end

        // set beats clear when both land in one cycle
        s_d.flags = (s_q.flags & ~flag_clr) | hit;

        rst_any  = |(hit & rst_mask) || (hit[PER] && (|s_q.pwm_en));
        stop_any = |(hit & stop_mask);

        if (s_q.clr) begin
            s_d.count = '0;
        end else if (step) begin
            if (rst_any)       s_d.count = '0;
            else if (stop_any) s_d.count = s_q.count;
            else               s_d.count = s_q.count + 1'b1;
        end

        if (step && stop_any) s_d.run = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(ADDR_CTRL))  rd_data = CW'({s_q.clr, s_q.run});
        if (rd_addr == AW'(ADDR_PRESC)) rd_data = s_q.limit;
        if (rd_addr == AW'(ADDR_COUNT)) rd_data = s_q.count;
        if (rd_addr == AW'(ADDR_FLAGS)) rd_data = CW'(s_q.flags);
        if (rd_addr == AW'(ADDR_IRQEN)) rd_data = CW'(s_q.irq_en);
        if (rd_addr == AW'(ADDR_PWMEN)) rd_data = CW'(s_q.pwm_en);
        for (int i = 0; i < NM; i++) begin
            if (rd_addr == AW'(MV_BASE + i)) rd_data = s_q.mr[i];
            if (rd_addr == AW'(MC_BASE + i)) rd_data = CW'(s_q.cfg[i]);
        end
    end

    assign flags   = s_q.flags;
    assign irq     = |(s_q.flags & s_q.irq_en);
    assign count_q = s_q.count;
    assign run_q   = s_q.run;
    assign clr_q   = s_q.clr;
endmodule

// File: rtl/mpt_checker.sv
module mpt_checker #(
    parameter int CW = 32,
    parameter int NM = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step,
    input logic          clr,
    input logic          run,
    input logic [CW-1:0] count,
    input logic [NM-1:0] hit,
    input logic [NM-1:0] rst_mask,
    input logic [NM-1:0] stop_mask,
    input logic [NM-1:0] flags
);
    // R3
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R2
    no_step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(count));

    // R5
    zero_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && |(hit & rst_mask)) |=> (count == '0));

    // R6
    halt_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && |(hit & stop_mask)) |=> !run);

    // R4
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(hit)) == '0));
endmodule

bind match_pwm_timer mpt_checker #(.CW(CW), .NM(NM)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .clr       (clr_q),
    .run       (run_q),
    .count     (count_q),
    .hit       (hit),
    .rst_mask  (rst_mask),
    .stop_mask (stop_mask),
    .flags     (flags)
);

// File: tb/match_pwm_timer_test.sv
module match_pwm_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tick = 1'b0;
    logic [3:0]  match_out;
    logic [3:0]  flags;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    match_pwm_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick(tick), .match_out(match_out), .flags(flags), .irq(irq)
    );

    // {prescale limit, tick count, expected count}
    localparam int unsigned PS_VEC [4][3] = '{
        '{0, 5, 5}, '{2, 9, 3}, '{3, 10, 2}, '{1, 7, 3}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(4'd2, v); chk("R1 count", v, 0);
        rd(4'd0, v); chk("R1 run", v, 0);
        chk("R1 flags", 32'(flags), 0);
        chk("R1 outputs", 32'(match_out), 0);
        chk("R1 irq", 32'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(4'd2, v); chk("R1 count after release", v, 0);

        // R2 prescale table
        foreach (PS_VEC[k]) begin
            wr(4'd1, PS_VEC[k][0]);
            wr(4'd0, 32'h2);
            wr(4'd0, 32'h1);
            ticks(int'(PS_VEC[k][1]));
            rd(4'd2, v); chk("R2 prescale vector", v, PS_VEC[k][2]);
        end

        // R3 count write ignored, then hold-clear
        wr(4'd2, 32'd100);
        rd(4'd2, v); chk("R3 count write ignored", v, 3);
        wr(4'd0, 32'h3);
        ticks(2);
        rd(4'd2, v); chk("R3 hold clear", v, 0);

        // R2 ticks with run off
        wr(4'd0, 32'h0);
        wr(4'd1, 32'd0);
        ticks(3);
        rd(4'd2, v); chk("R2 run off", v, 0);

        // R4 R5 R7 toggle with zero-on-match
        wr(4'd0, 32'h2);
        wr(4'd9, 32'd1000); wr(4'd10, 32'd1000); wr(4'd11, 32'd1000);
        wr(4'd8, 32'd3);
        wr(4'd12, 32'h0D);
        wr(4'd4, 32'h1);
        wr(4'd3, 32'hF);
        wr(4'd0, 32'h1);
        chk("R7 init level 0", 32'(match_out), 0);
        chk("R8 irq idle", 32'(irq), 0);
        ticks(4);
        rd(4'd2, v); chk("R5 zero on match", v, 0);
        chk("R4 flag set", 32'(flags), 1);
        chk("R7 toggle high", 32'(match_out), 1);
        chk("R8 irq on", 32'(irq), 1);
        ticks(4);
        chk("R7 toggle low", 32'(match_out), 0);
        wr(4'd3, 32'h1);
        chk("R8 w1c", 32'(flags), 0);
        chk("R8 irq off", 32'(irq), 0);

        // R8 set wins over clear
        ticks(3);
        rd(4'd2, v); chk("R2 count before collide", v, 3);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd3; wr_data = 32'h1;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        chk("R8 set wins", 32'(flags), 1);

        // R6 halt with set action
        wr(4'd0, 32'h2);
        wr(4'd3, 32'hF);
        wr(4'd12, 32'h0); wr(4'd8, 32'd1000);
        wr(4'd9, 32'd2);
        wr(4'd13, 32'h0A);
        wr(4'd0, 32'h1);
        ticks(3);
        rd(4'd2, v); chk("R6 count holds", v, 2);
        rd(4'd0, v); chk("R6 run cleared", v, 0);
        chk("R7 set action", 32'(match_out), 32'h2);
        ticks(2);
        rd(4'd2, v); chk("R6 stays stopped", v, 2);

        // R11 simultaneous matches with halt, R7 clear action
        wr(4'd0, 32'h2);
        wr(4'd3, 32'hF);
        wr(4'd4, 32'h0);
        wr(4'd8, 32'd4); wr(4'd9, 32'd4); wr(4'd10, 32'd4);
        wr(4'd12, 32'h0); wr(4'd13, 32'h0); wr(4'd14, 32'h16);
        chk("R7 init load high", 32'(match_out), 32'h4);
        wr(4'd0, 32'h1);
        ticks(5);
        chk("R11 all flags", 32'(flags), 32'h7);
        rd(4'd2, v); chk("R11 count held", v, 4);
        rd(4'd0, v); chk("R11 run cleared", v, 0);
        chk("R7 clear action", 32'(match_out), 0);
        chk("R8 irq masked", 32'(irq), 0);

        // R9 R10 R12 pulse-width
        wr(4'd0, 32'h2);
        wr(4'd14, 32'h0); wr(4'd15, 32'h0);
        wr(4'd11, 32'd9); wr(4'd8, 32'd4); wr(4'd9, 32'd0); wr(4'd10, 32'd20);
        wr(4'd5, 32'hF);
        wr(4'd3, 32'hF);
        wr(4'd0, 32'h1);
        rd(4'd5, v); chk("R9 bit3 absent", v, 32'h7);
        chk("R9 zero value high", 32'(match_out), 32'h2);
        ticks(2);
        chk("R9 below value", 32'(match_out), 32'h2);
        ticks(2);
        chk("R9 at value", 32'(match_out), 32'h3);
        ticks(6);
        rd(4'd2, v); chk("R10 period restart", v, 0);
        chk("R10 flags", 32'(flags), 32'hB);
        chk("R9 low after restart", 32'(match_out), 32'h2);
        wr(4'd8, 32'd2);
        ticks(3);
        chk("R12 new width", 32'(match_out), 32'h3);

        finish_run();
    end
endmodule